// File: doc/BRIEF.md
# Programmable Cube Calculus Iterative Array

This block applies a programmable operation of multiple-valued cube calculus to two operand cubes A and B. Each cube is held in a 32-bit word in positional notation. The word is split into 2-bit cells, and each cell holds one bit for each value that its variable may take. Adjacent cells may be grouped into a wider variable field. Four small truth tables describe the operation. One table is a relation that marks a field as a candidate. The other three are cell functions: one fills the active field, one fills the fields to its left and one fills the fields to its right. Each table is indexed by the A and B slices of a cell. Reloading these tables turns the same array into intersection, supercube, prime, crosslink, sharp, disjoint sharp or many other operations.

In combinational mode the array produces a single result cube. In sequential mode it evaluates every field's relation at once. It then hands out one result cube per candidate field, starting with the leftmost field, and waits for the consumer to pulse `nxt` before moving on. An empty result cube is never presented. When no cube can be produced, the run ends with a "no result" indication.

Top module: `cube_calc_array`

## Requirements
- R1: After reset, `res_valid`, `done` and `no_result` are all 0.
- R2: Each bit of `fld_lo` belongs to one cell. A bit of 1 marks cell i (bits 2i+1:2i) as the rightmost cell of its field, and cell 0 always ends a field. Cell 15 (bits 31:30) is the leftmost cell. A field's relation is the OR of its cells' relation bits when `or_comb`=1 and the AND of them when `or_comb`=0. A field is empty when all of its bits are 0.
- R3: With `seq_mode`=0, one cube is presented. Each field carries the active function if its relation holds and the right-side function otherwise. The cube stays valid until `nxt`, and `done` pulses afterwards.
- R4: With `seq_mode`=0, if that cube has an empty field, no cube is presented and `done` pulses together with `no_result`.
- R5: With `seq_mode`=1, each result cube carries the active function on one field whose relation holds. Every field to its left carries the left function and every field to its right carries the right function.
- R6: Sequential results are presented from the leftmost candidate field to the rightmost. For binary fields, xxx1 # 111x gives 0xx1, x0x1, xx01 in that order.
- R7: A candidate whose cube has an empty field is skipped. The number of valid results equals the number of non-empty cubes.
- R8: If there is no candidate, or every candidate is empty, `done` pulses with `no_result`=1 and no cube is presented.
- R9: While `res_valid`=1 and `nxt`=0, `res` and `res_valid` hold.
- R10: A `start` while a run is in progress is ignored. The run finishes with its original operands.
- R11: When `tbl_we`=1, `tbl_data` is written into the table chosen by `tbl_sel`: 0 relation, 1 right function, 2 active function, 3 left function. The index is k={a,b} (A slice high, B slice low). The relation uses bit k, and a function uses bits 2k+1:2k. Reset leaves the tables unchanged.
- R12: A reset during a run drops `res_valid` and discards the remaining candidates, so no further cube or `done` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; operands, mask and modes are captured |
| op_a | input | 32 | Operand cube A |
| op_b | input | 32 | Operand cube B |
| fld_lo | input | 16 | Field boundary mask, one bit per cell |
| seq_mode | input | 1 | 1 sequential, 0 combinational |
| or_comb | input | 1 | 1 OR-reduce, 0 AND-reduce the relation over a field |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 2 | Table select |
| tbl_data | input | 32 | Table contents |
| nxt | input | 1 | Consumer takes the current result |
| res | output | 32 | Result cube |
| res_valid | output | 1 | `res` holds a result |
| no_result | output | 1 | Run produced nothing (with `done`) |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A corrupted candidate set would show up as a missing, duplicated or out-of-order cube in the first or second result of a sequential run. A wrong field grouping would alter the relation or the emptiness decision, and so change the result count or flip `no_result` on the same `done` pulse. A handshake fault would show up within a cycle of `nxt`, as a cube that changes while it is held or that disappears without `nxt`. Runs with 2-bit fields and runs with mixed widths are compared against an independent field-level model. The sharp example is also compared against hand-written cubes.

// File: rtl/cube_pkg.sv
package cube_pkg;
    localparam int CELL_W    = 2;
    localparam int LUT_IDX_W = 2 * CELL_W;
    localparam int LUT_N     = 1 << LUT_IDX_W;
    localparam int FN_TBL_W  = CELL_W * LUT_N;

    typedef logic [CELL_W-1:0] kit_t;

    typedef enum logic [1:0] {
        TBL_REL = 2'd0,
        TBL_BEF = 2'd1,
        TBL_ACT = 2'd2,
        TBL_AFT = 2'd3
    } tbl_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_PICK,
        ST_SHOW
    } seq_state_e;

    typedef struct packed {
        logic rel;
        kit_t bef;
        kit_t act;
        kit_t aft;
    } cell_fn_t;

    function automatic int lut_index(kit_t a, kit_t b);
        return int'({a, b});
    endfunction

    function automatic kit_t kit_lookup(logic [FN_TBL_W-1:0] tbl, kit_t a, kit_t b);
        return tbl[lut_index(a, b)*CELL_W +: CELL_W];
    endfunction

    function automatic logic bit_lookup(logic [LUT_N-1:0] tbl, kit_t a, kit_t b);
        return tbl[lut_index(a, b)];
    endfunction
endpackage

// File: rtl/cube_cell.sv
module cube_cell
    import cube_pkg::*;
(
    input  kit_t                 a_kit,
    input  kit_t                 b_kit,
    input  logic [LUT_N-1:0]     rel_tbl,
    input  logic [FN_TBL_W-1:0]  bef_tbl,
    input  logic [FN_TBL_W-1:0]  act_tbl,
    input  logic [FN_TBL_W-1:0]  aft_tbl,
    output cell_fn_t             fn
);
    always_comb begin
        fn.rel = bit_lookup(rel_tbl, a_kit, b_kit);
        fn.bef = kit_lookup(bef_tbl, a_kit, b_kit);
        fn.act = kit_lookup(act_tbl, a_kit, b_kit);
        fn.aft = kit_lookup(aft_tbl, a_kit, b_kit);
    end
endmodule

// File: rtl/cube_field_map.sv
module cube_field_map #(
    parameter int NCELL = 16
) (
    input  logic [NCELL-1:0]            fld_lo,
    output logic [NCELL-1:0]            head,
    output logic [NCELL-1:0][NCELL-1:0] member
);
    // head[h]: cell h is the leftmost cell of its field
    for (genvar h = 0; h < NCELL; h++) begin : g_head
        if (h == NCELL-1) begin : g_top
            assign head[h] = 1'b1;
        end else begin : g_mid
            assign head[h] = fld_lo[h+1];
        end
    end

    // member[h][i]: cell i lies in the field whose leftmost cell is h
    always_comb begin
        logic open;
        for (int h = 0; h < NCELL; h++) begin
            open = head[h];
            for (int i = NCELL-1; i >= 0; i--) begin
                if (i <= h) begin
                    member[h][i] = open;
                    if (fld_lo[i]) open = 1'b0;
                end else begin
                    member[h][i] = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/cube_assemble.sv
module cube_assemble
    import cube_pkg::*;
#(
    parameter int NCELL  = 16,
    localparam int WORD_W = NCELL * CELL_W
) (
    input  cell_fn_t [NCELL-1:0]        fns,
    input  logic [NCELL-1:0]            head,
    input  logic [NCELL-1:0][NCELL-1:0] member,
    input  logic [NCELL-1:0]            pick,
    input  logic                        comb,
    input  logic                        or_comb,
    output logic [NCELL-1:0]            fld_rel,
    output logic [WORD_W-1:0]           cube,
    output logic                        empty
);
    logic [NCELL-1:0] rel_v;
    logic [NCELL-1:0] nz;

    // field relation, reduced over the cells of each field
    always_comb begin
        for (int i = 0; i < NCELL; i++) rel_v[i] = fns[i].rel;
        for (int h = 0; h < NCELL; h++) begin
            fld_rel[h] = head[h] & (or_comb ? |(rel_v & member[h])
                                            : &(rel_v | ~member[h]));
        end
    end

    // per cell: active / left / right choice, then field emptiness
    always_comb begin
        logic in_act, in_left, cell_rel;
        kit_t k;
        empty = 1'b0;
        for (int i = 0; i < NCELL; i++) begin
            in_act   = 1'b0;
            in_left  = 1'b0;
            cell_rel = 1'b0;
            for (int h = 0; h < NCELL; h++) begin
                if (member[h][i]) begin
                    in_act   = in_act | pick[h];
                    cell_rel = cell_rel | fld_rel[h];
                end
                if (h < i) in_left = in_left | pick[h];
            end
            if (comb)         k = cell_rel ? fns[i].act : fns[i].bef;
            else if (in_act)  k = fns[i].act;
            else if (in_left) k = fns[i].aft;
            else              k = fns[i].bef;
            cube[i*CELL_W +: CELL_W] = k;
            nz[i] = |k;
        end
        for (int h = 0; h < NCELL; h++) begin
            if (head[h] && !(|(nz & member[h]))) empty = 1'b1;
        end
    end
endmodule

// File: rtl/cube_seq.sv
module cube_seq
    import cube_pkg::*;
#(
    parameter int NCELL  = 16,
    localparam int WORD_W = NCELL * CELL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              seq_mode,
    input  logic [NCELL-1:0]  fld_rel,
    input  logic [WORD_W-1:0] cube,
    input  logic              cube_empty,
    input  logic              nxt,
    output logic [NCELL-1:0]  pick,
    output logic              capture,
    output logic              busy,
    output logic [WORD_W-1:0] res,
    output logic              res_valid,
    output logic              no_result,
    output logic              done
);
    seq_state_e       state;
    logic [NCELL-1:0] pend;
    logic [NCELL-1:0] rest;
    logic             any_out;

    // leftmost pending candidate
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = NCELL-1; i >= 0; i--) begin
            if (pend[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    assign rest    = pend & ~pick;
    assign capture = start && (state == ST_IDLE);
    assign busy    = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pend      <= '0;
            any_out   <= 1'b0;
            res       <= '0;
            res_valid <= 1'b0;
            no_result <= 1'b0;
            done      <= 1'b0;
        end else begin
            done      <= 1'b0;
            no_result <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_EVAL;
                        any_out <= 1'b0;
                    end
                end
                ST_EVAL: begin
                    if (seq_mode) begin
                        pend <= fld_rel;
                        if (fld_rel == '0) begin
                            done      <= 1'b1;
                            no_result <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            state <= ST_PICK;
                        end
                    end else begin
                        pend <= '0;
                        if (cube_empty) begin
                            done      <= 1'b1;
                            no_result <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            res       <= cube;
                            res_valid <= 1'b1;
                            any_out   <= 1'b1;
                            state     <= ST_SHOW;
                        end
                    end
                end
                ST_PICK: begin
                    pend <= rest;
                    if (!cube_empty) begin
                        res       <= cube;
                        res_valid <= 1'b1;
                        any_out   <= 1'b1;
                        state     <= ST_SHOW;
                    end else if (rest == '0) begin
                        done      <= 1'b1;
                        no_result <= !any_out;
                        state     <= ST_IDLE;
                    end
                end
                ST_SHOW: begin
                    if (nxt) begin
                        res_valid <= 1'b0;
                        if (pend == '0) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_PICK;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_PEND_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
        (state != ST_EVAL) |=> ((pend & ~$past(pend)) == '0)); // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !nxt) |=> (res_valid && $stable(res))); // R9
    AST_DONE_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
        done |-> !res_valid); // R3
    AST_NORES_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        no_result |-> done); // R8
endmodule

// File: rtl/cube_calc_array.sv
module cube_calc_array
    import cube_pkg::*;
#(
    parameter int NCELL  = 16,
    localparam int WORD_W = NCELL * CELL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [NCELL-1:0]  fld_lo,
    input  logic              seq_mode,
    input  logic              or_comb,
    input  logic              tbl_we,
    input  logic [1:0]        tbl_sel,
    input  logic [FN_TBL_W-1:0] tbl_data,
    input  logic              nxt,
    output logic [WORD_W-1:0] res,
    output logic              res_valid,
    output logic              no_result,
    output logic              done
);
    logic [WORD_W-1:0]   a_q, b_q;
    logic [NCELL-1:0]    lo_q;
    logic                seq_q, orc_q;
    logic [LUT_N-1:0]    rel_tbl;
    logic [FN_TBL_W-1:0] bef_tbl, act_tbl, aft_tbl;

    logic                        capture, busy, cube_empty;
    logic [NCELL-1:0]            head, pick, fld_rel;
    logic [NCELL-1:0][NCELL-1:0] member;
    cell_fn_t [NCELL-1:0]        fns;
    logic [WORD_W-1:0]           cube;

    // operation tables: kept across reset
    always_ff @(posedge clk) begin
        if (tbl_we) begin
            case (tbl_sel_e'(tbl_sel))
                TBL_REL: rel_tbl <= tbl_data[LUT_N-1:0];
                TBL_BEF: bef_tbl <= tbl_data;
                TBL_ACT: act_tbl <= tbl_data;
                TBL_AFT: aft_tbl <= tbl_data;
                default: ;
            endcase
        end
    end

    // run operands, captured only from idle
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            lo_q  <= '0;
            seq_q <= 1'b0;
            orc_q <= 1'b0;
        end else if (capture) begin
            a_q   <= op_a;
            b_q   <= op_b;
            lo_q  <= fld_lo;
            seq_q <= seq_mode;
            orc_q <= or_comb;
        end
    end

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        cube_cell u_cell (
            .a_kit   (a_q[i*CELL_W +: CELL_W]),
            .b_kit   (b_q[i*CELL_W +: CELL_W]),
            .rel_tbl (rel_tbl),
            .bef_tbl (bef_tbl),
            .act_tbl (act_tbl),
            .aft_tbl (aft_tbl),
            .fn      (fns[i])
        );
    end

    cube_field_map #(.NCELL(NCELL)) u_map (
        .fld_lo (lo_q),
        .head   (head),
        .member (member)
    );

    cube_assemble #(.NCELL(NCELL)) u_asm (
        .fns     (fns),
        .head    (head),
        .member  (member),
        .pick    (pick),
        .comb    (!seq_q),
        .or_comb (orc_q),
        .fld_rel (fld_rel),
        .cube    (cube),
        .empty   (cube_empty)
    );

    cube_seq #(.NCELL(NCELL)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .seq_mode   (seq_q),
        .fld_rel    (fld_rel),
        .cube       (cube),
        .cube_empty (cube_empty),
        .nxt        (nxt),
        .pick       (pick),
        .capture    (capture),
        .busy       (busy),
        .res        (res),
        .res_valid  (res_valid),
        .no_result  (no_result),
        .done       (done)
    );

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(a_q) && $stable(b_q))); // R10
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!res_valid && !done && !no_result)); // R12
    AST_ACT_TABLE_WRITE: assert property (@(posedge clk)
        (tbl_we && tbl_sel == 2'd2) |=> (act_tbl == $past(tbl_data))); // R11
endmodule

// File: tb/cube_calc_array_bench.sv
`timescale 1ns/1ps
module cube_calc_array_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [15:0] fld_lo = 16'hFFFF;
    logic        seq_mode = 1'b0, or_comb = 1'b0;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_sel = 2'd0;
    logic [31:0] tbl_data = '0;
    logic        nxt = 1'b0;
    logic [31:0] res;
    logic        res_valid, no_result, done;

    int checks = 0;
    int fails  = 0;

    logic [15:0] tb_rel;
    logic [31:0] tb_bef, tb_act, tb_aft;
    logic [31:0] exp_q [16];
    int          exp_n;
    bit          exp_nores;
    logic [31:0] got_q [16];
    int          got_n;

    always #2.5 clk = ~clk;

    cube_calc_array u_cube_calc_array (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .fld_lo(fld_lo), .seq_mode(seq_mode), .or_comb(or_comb),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_data(tbl_data), .nxt(nxt),
        .res(res), .res_valid(res_valid), .no_result(no_result), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // function codes: 0 A&B, 1 A|B, 2 A, 3 B, 4 A&~B
    function automatic logic [1:0] fn_bits(int code, logic [1:0] a, logic [1:0] b);
        case (code)
            0: return a & b;
            1: return a | b;
            2: return a;
            3: return b;
            default: return a & ~b;
        endcase
    endfunction

    // relation codes: 0 true, 1 A&B nonempty, 2 A&B empty, 3 A not inside B
    function automatic logic rel_bit(int code, logic [1:0] a, logic [1:0] b);
        case (code)
            0: return 1'b1;
            1: return (a & b) != 2'b00;
            2: return (a & b) == 2'b00;
            default: return (a & ~b) != 2'b00;
        endcase
    endfunction

    task automatic write_tbl(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = sel; tbl_data = data;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // R11: table layout, index k = {a,b}
    task automatic load_op(input int relc, input int befc, input int actc, input int aftc);
        for (int k = 0; k < 16; k++) begin
            tb_rel[k]        = rel_bit(relc, k[3:2], k[1:0]);
            tb_bef[2*k +: 2] = fn_bits(befc, k[3:2], k[1:0]);
            tb_act[2*k +: 2] = fn_bits(actc, k[3:2], k[1:0]);
            tb_aft[2*k +: 2] = fn_bits(aftc, k[3:2], k[1:0]);
        end
        write_tbl(2'd0, {16'h0, tb_rel});
        write_tbl(2'd1, tb_bef);
        write_tbl(2'd2, tb_act);
        write_tbl(2'd3, tb_aft);
    endtask

    // field-level model of the requirements
    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [15:0] lo,
                         input bit sq, input bit orc);
        int fhi [16];
        int flo [16];
        bit frel [16];
        int nf, hi;
        logic [31:0] cube;
        bit empty, acc, fnz;
        logic [1:0] v, ca, cb;
        nf = 0; hi = 15;
        for (int i = 15; i >= 0; i--) begin
            if (i == 0 || lo[i]) begin
                fhi[nf] = hi; flo[nf] = i; nf++; hi = i - 1;
            end
        end
        for (int f = 0; f < nf; f++) begin
            acc = !orc;
            for (int c = flo[f]; c <= fhi[f]; c++) begin
                if (orc) acc = acc | tb_rel[{a[2*c +: 2], b[2*c +: 2]}];
                else     acc = acc & tb_rel[{a[2*c +: 2], b[2*c +: 2]}];
            end
            frel[f] = acc;
        end
        exp_n = 0;
        for (int k = 0; k < (sq ? nf : 1); k++) begin
            if (sq && !frel[k]) continue;
            empty = 1'b0;
            cube = '0;
            for (int f = 0; f < nf; f++) begin
                fnz = 1'b0;
                for (int c = flo[f]; c <= fhi[f]; c++) begin
                    ca = a[2*c +: 2]; cb = b[2*c +: 2];
                    if (!sq)         v = frel[f] ? tb_act[2*{ca,cb} +: 2] : tb_bef[2*{ca,cb} +: 2];
                    else if (f == k) v = tb_act[2*{ca,cb} +: 2];
                    else if (f < k)  v = tb_aft[2*{ca,cb} +: 2];
                    else             v = tb_bef[2*{ca,cb} +: 2];
                    cube[2*c +: 2] = v;
                    fnz = fnz | (v != 2'b00);
                end
                if (!fnz) empty = 1'b1;
            end
            if (!empty) begin
                exp_q[exp_n] = cube;
                exp_n++;
            end
        end
        exp_nores = (exp_n == 0);
    endtask

    // one run; hold: check R9 on first result; poke: start while busy (R10)
    task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] lo, input bit sq, input bit orc,
                          input bit hold, input bit poke);
        bit fin, first;
        logic [31:0] snap;
        model(a, b, lo, sq, orc);
        got_n = 0; fin = 0; first = 1;
        @(negedge clk);
        op_a = a; op_b = b; fld_lo = lo; seq_mode = sq; or_comb = orc; start = 1'b1;
        for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
            @(negedge clk);
            nxt = 1'b0; start = 1'b0;
            if (done) begin
                fin = 1;
                chk(got_n == exp_n, {tag, " result count"}, got_n, exp_n);
                chk(no_result == exp_nores, {tag, " R8 no_result at done"}, no_result, exp_nores);
            end else if (res_valid) begin
                if (first && hold) begin
                    snap = res;
                    repeat (3) @(negedge clk);
                    chk(res_valid && res == snap, {tag, " R9 held result"}, res, snap);
                end
                if (first && poke) begin
                    start = 1'b1; op_a = ~a; op_b = ~b;
                    @(negedge clk);
                    start = 1'b0;
                end
                first = 0;
                if (got_n < 16) got_q[got_n] = res;
                chk(got_n < exp_n && res == exp_q[got_n % 16], {tag, " cube"}, res,
                    exp_q[got_n % 16]);
                got_n++;
                nxt = 1'b1;
            end
        end
        chk(fin, {tag, " run finished"}, 32'(fin), 32'd1);
        @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!res_valid && !done && !no_result, "R1 reset outputs",
            {29'd0, res_valid, done, no_result}, 32'd0);
    endtask

    task automatic t_comb_inter;
        load_op(0, 0, 0, 0);
        run_op("R3/R11 comb intersection", 32'hFFFF_FFFF, 32'h7D6F_B5E7, 16'hFFFF, 0, 0, 1, 0);
        chk(got_q[0] == 32'h7D6F_B5E7, "R3 intersection with full cube", got_q[0], 32'h7D6F_B5E7);
    endtask

    task automatic t_comb_empty_and_width;
        run_op("R4 comb empty", 32'hFFFF_FFFE, 32'hFFFF_FFFD, 16'hFFFF, 0, 0, 0, 0);
        chk(got_n == 0, "R4 no cube for empty literal", got_n, 0);
        run_op("R2 4-bit field", 32'hFFFF_FFFE, 32'hFFFF_FFFD, 16'hFFFD, 0, 0, 0, 0);
        chk(got_n == 1 && got_q[0] == 32'hFFFF_FFFC, "R2 wide field not empty", got_q[0], 32'hFFFF_FFFC);
    endtask

    task automatic t_comb_prime;
        load_op(1, 2, 1, 2);
        run_op("R3 comb prime", 32'h9C3A_5F61, 32'h1E62_D3B4, 16'h1717, 0, 1, 0, 0);
    endtask

    task automatic t_sharp;
        load_op(3, 2, 4, 2);
        run_op("R5/R6 sharp", 32'hFFFF_FFFD, 32'hFFFF_FF57, 16'hFFFF, 1, 1, 1, 0);
        chk(got_n == 3 && got_q[0] == 32'hFFFF_FFBD, "R6 first 0xx1", got_q[0], 32'hFFFF_FFBD);
        chk(got_q[1] == 32'hFFFF_FFED, "R6 second x0x1", got_q[1], 32'hFFFF_FFED);
        chk(got_q[2] == 32'hFFFF_FFF9, "R6 third xx01", got_q[2], 32'hFFFF_FFF9);
        run_op("R2/R5 sharp mixed widths", 32'h9C3A_5F61, 32'h1E62_D3B4, 16'h1717, 1, 1, 0, 0);
    endtask

    task automatic t_other_seq;
        load_op(3, 2, 4, 0);
        run_op("R5 disjoint sharp", 32'hFFFF_FFFD, 32'hFFFF_FF57, 16'hFFFF, 1, 1, 0, 0);
        chk(got_q[1] == 32'hFFFF_FF6D, "R5 left field gets A&B", got_q[1], 32'hFFFF_FF6D);
        load_op(2, 2, 1, 3);
        run_op("R5 crosslink", 32'h6B5A_F0E7, 32'h94A5_0F1B, 16'hFFFF, 1, 0, 0, 0);
    endtask

    task automatic t_skip_and_none;
        load_op(0, 2, 0, 2);
        run_op("R7 skip empty", 32'hFFFF_FF6B, 32'hFFFF_FF97, 16'hFFFF, 1, 0, 0, 0);
        chk(got_n == 13, "R7 only non-empty cubes", got_n, 13);
        run_op("R8 all candidates empty", 32'hFFFF_FF1B, 32'hFFFF_FF4E, 16'hFFFF, 1, 0, 0, 0);
        load_op(3, 2, 4, 2);
        run_op("R8 no candidate", 32'h1234_5678, 32'hFFFF_FFFF, 16'hFFFF, 1, 1, 0, 0);
    endtask

    task automatic t_busy_start;
        run_op("R10 start while busy", 32'hFFFF_FFFD, 32'hFFFF_FF57, 16'hFFFF, 1, 1, 0, 1);
        chk(got_q[2] == 32'hFFFF_FFF9, "R10 original operands kept", got_q[2], 32'hFFFF_FFF9);
    endtask

    task automatic t_mid_reset;
        bit seen, stray;
        seen = 0; stray = 0;
        @(negedge clk);
        op_a = 32'hFFFF_FFFD; op_b = 32'hFFFF_FF57; fld_lo = 16'hFFFF;
        seq_mode = 1'b1; or_comb = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            seen = res_valid;
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(seen && !res_valid, "R12 valid dropped by reset", {31'd0, res_valid}, 32'd0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (res_valid || done) stray = 1;
        end
        chk(!stray, "R12 no cube or done after reset", {31'd0, stray}, 32'd0);
        run_op("R11/R12 tables kept over reset", 32'hFFFF_FFFD, 32'hFFFF_FF57, 16'hFFFF, 1, 1, 0, 0);
    endtask

    initial begin
        t_reset();
        t_comb_inter();
        t_comb_empty_and_width();
        t_comb_prime();
        t_sharp();
        t_other_seq();
        t_skip_and_none();
        t_busy_start();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule